// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership flags that two agents, a left port and a right port, use to share resources without touching shared memory. Each flag is either free or held by exactly one side. A side asks for a flag by writing 0 on data bit 0 and gives it back by writing 1. Reading a flag returns one status bit copied across the whole data word. The bit is 0 when the reading side holds the token and 1 otherwise.

A request that arrives while the other side holds the flag is not dropped. It is recorded as pending for that side. When the holder releases, the token goes straight to the waiting side, and that side does not have to ask again. Each side can have at most one pending request per flag. A side cancels its pending request by writing 1. All state is registered on the rising clock edge. Reads are combinational from the registered state.

Top module: `sem_bank`

## Requirements
- R1: A port performs a semaphore access only when its chip enable (active low) is high and its semaphore select (active low) is low. Any other combination leaves all flags unchanged, and the port's read data is then all ones.
- R2: The 3-bit address selects one of eight flags. An access changes only the addressed flag.
- R3: A write is an access with write enable (active low) low. Only data bit 0 is used, so bit 0 = 0 is a request and bit 0 = 1 is a release. The other data bits have no effect.
- R4: During a read access, every bit of the port's read data equals the status of the addressed flag. The status is 0 when that port holds the token and 1 otherwise. The two ports never both read 0 for the same flag.
- R5: A request to a free flag gives the token to the requester from the next cycle. The requester then reads 0 and the other side reads 1.
- R6: A request from the side that does not hold the token causes no visible change in either port's read value.
- R7: When the holder releases and the other side has a pending request, the token passes to the other side in the next cycle.
- R8: When the holder releases and nothing is pending, the flag becomes free, and both sides read 1.
- R9: A release written by the non-holder cancels its pending request, so a later release by the holder frees the flag.
- R10: When both ports request the same free flag in the same cycle, the left port gets the token and the right request becomes pending.
- R11: After reset all eight flags are free and none has a pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_en_n | input | 1 | Left chip enable, active low; must be high for a semaphore access |
| lt_sem_n | input | 1 | Left semaphore select, active low |
| lt_we_n | input | 1 | Left write enable, active low |
| lt_addr | input | 3 | Left flag index |
| lt_wdata | input | 36 | Left write data; only bit 0 is used |
| lt_rdata | output | 36 | Left read data, status copied on every bit |
| rt_en_n | input | 1 | Right chip enable, active low |
| rt_sem_n | input | 1 | Right semaphore select, active low |
| rt_we_n | input | 1 | Right write enable, active low |
| rt_addr | input | 3 | Right flag index |
| rt_wdata | input | 36 | Right write data; only bit 0 is used |
| rt_rdata | output | 36 | Right read data |

## Verification
Directed sequences on one flag take it through each transition:
- free to held,
- a losing request,
- handoff in both directions,
- release to free,
- cancellation of a pending request,
- a same-cycle tie.

These separate a handoff from a plain release, and a cancelled request from a live one. Further writes carry junk in the upper data bits or a blocked enable and select combination. They show that only bit 0 and a valid access change state. A long pseudo-random run then drives both ports with random operations, addresses and enables. After every step it reads all eight flags from both sides. This exposes any crosstalk between flags and any wrong priority when both ports write in the same cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Status bit seen by one side: 0 when that side holds the token.
  function automatic logic side_status(input owner_e own, input logic is_left);
    if (is_left) return (own != OWN_LEFT);
    else         return (own != OWN_RIGHT);
  endfunction
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NSEM = 8,
  localparam int AW = $clog2(NSEM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_n,
  input  logic            sem_n,
  input  logic            we_n,
  input  logic [AW-1:0]   addr,
  input  logic            wbit,
  output logic            acc,
  output logic [NSEM-1:0] req_vec,
  output logic [NSEM-1:0] rel_vec
);
  logic wr_acc;

  assign acc    = en_n & ~sem_n;
  assign wr_acc = acc & ~we_n;

  always_comb begin
    req_vec = '0;
    rel_vec = '0;
    for (int i = 0; i < NSEM; i++) begin
      if (wr_acc && (addr == AW'(i))) begin
        req_vec[i] = ~wbit;
        rel_vec[i] = wbit;
      end
    end
  end

  AST_ONE_FLAG_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec | rel_vec)) else $error("two flags touched"); // R2
  AST_NO_ACCESS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_n && !sem_n) |-> ((req_vec | rel_vec) == '0)) else $error("write without access"); // R1
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   l_req,
  input  logic   l_rel,
  input  logic   r_req,
  input  logic   r_rel,
  output owner_e owner
);
  logic   l_pend, r_pend;
  owner_e owner_nx;
  logic   l_pend_nx, r_pend_nx;
  logic   r_waiting, l_waiting;

  // A side still waiting after this cycle's own write.
  assign r_waiting = (r_pend & ~r_rel) | r_req;
  assign l_waiting = (l_pend & ~l_rel) | l_req;

  always_comb begin
    owner_nx  = owner;
    l_pend_nx = l_pend;
    r_pend_nx = r_pend;
    unique case (owner)
      OWN_FREE: begin
        if (l_req) begin
          owner_nx  = OWN_LEFT;
          r_pend_nx = r_req;
        end else if (r_req) begin
          owner_nx = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (l_rel) begin
          owner_nx  = r_waiting ? OWN_RIGHT : OWN_FREE;
          r_pend_nx = 1'b0;
        end else begin
          r_pend_nx = r_waiting;
        end
      end
      OWN_RIGHT: begin
        if (r_rel) begin
          owner_nx  = l_waiting ? OWN_LEFT : OWN_FREE;
          l_pend_nx = 1'b0;
        end else begin
          l_pend_nx = l_waiting;
        end
      end
      default: owner_nx = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner  <= OWN_FREE;
      l_pend <= 1'b0;
      r_pend <= 1'b0;
    end else begin
      owner  <= owner_nx;
      l_pend <= l_pend_nx;
      r_pend <= r_pend_nx;
    end
  end

  AST_PEND_NOT_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_pend && owner == OWN_LEFT) && !(r_pend && owner == OWN_RIGHT)) else $error("holder pending"); // R6
  AST_FREE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_FREE) |-> (!l_pend && !r_pend)) else $error("pending on free flag"); // R8
  AST_HANDOFF_TO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_LEFT && l_rel && r_pend && !r_rel) |=> (owner == OWN_RIGHT)) else $error("no handoff"); // R7
  AST_RELEASE_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_LEFT && l_rel && !r_pend && !r_req) |=> (owner == OWN_FREE)) else $error("not freed"); // R8
  AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_FREE && l_req && r_req) |=> (owner == OWN_LEFT && r_pend)) else $error("tie lost"); // R10
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NSEM = 8,
  parameter int DW   = 36,
  localparam int AW  = $clog2(NSEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lt_en_n,
  input  logic          lt_sem_n,
  input  logic          lt_we_n,
  input  logic [AW-1:0] lt_addr,
  input  logic [DW-1:0] lt_wdata,
  output logic [DW-1:0] lt_rdata,
  input  logic          rt_en_n,
  input  logic          rt_sem_n,
  input  logic          rt_we_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_wdata,
  output logic [DW-1:0] rt_rdata
);
  logic            lt_acc, rt_acc;
  logic [NSEM-1:0] lt_req, lt_rel, rt_req, rt_rel;
  owner_e          own [NSEM];
  logic            lt_stat, rt_stat;

  sem_port_dec #(.NSEM(NSEM)) u_dec_lt (
    .clk(clk), .rst_n(rst_n), .en_n(lt_en_n), .sem_n(lt_sem_n), .we_n(lt_we_n),
    .addr(lt_addr), .wbit(lt_wdata[0]), .acc(lt_acc), .req_vec(lt_req), .rel_vec(lt_rel));

  sem_port_dec #(.NSEM(NSEM)) u_dec_rt (
    .clk(clk), .rst_n(rst_n), .en_n(rt_en_n), .sem_n(rt_sem_n), .we_n(rt_we_n),
    .addr(rt_addr), .wbit(rt_wdata[0]), .acc(rt_acc), .req_vec(rt_req), .rel_vec(rt_rel));

  for (genvar g = 0; g < NSEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l_req(lt_req[g]), .l_rel(lt_rel[g]),
      .r_req(rt_req[g]), .r_rel(rt_rel[g]),
      .owner(own[g]));
  end

  assign lt_stat  = side_status(own[lt_addr], 1'b1);
  assign rt_stat  = side_status(own[rt_addr], 1'b0);
  assign lt_rdata = lt_acc ? {DW{lt_stat}} : '1;
  assign rt_rdata = rt_acc ? {DW{rt_stat}} : '1;

  AST_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_acc && rt_acc && lt_addr == rt_addr) |-> (lt_rdata[0] || rt_rdata[0])) else $error("both hold"); // R4
  AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_acc |-> (lt_rdata == '1)) else $error("idle read not ones"); // R1
endmodule

// File: tb/sim_sem_bank.sv
`timescale 1ns/1ps
module sim_sem_bank;
  localparam int DW = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lt_en_n = 1'b0, lt_sem_n = 1'b1, lt_we_n = 1'b1;
  logic rt_en_n = 1'b0, rt_sem_n = 1'b1, rt_we_n = 1'b1;
  logic [2:0] lt_addr = '0, rt_addr = '0;
  logic [DW-1:0] lt_wdata = '0, rt_wdata = '0, lt_rdata, rt_rdata;

  int checks = 0, failures = 0;
  int m_own [8];           // 0 free, 1 left, 2 right
  bit m_lp [8], m_rp [8];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;   // 50 MHz

  sem_bank u0 (.*);

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: apply one cycle of writes to the model.
  task automatic model(input bit lv, input bit lb, input int la,
                       input bit rv, input bit rb, input int ra);
    for (int i = 0; i < 8; i++) begin
      bit lq = lv && la == i && !lb, lr = lv && la == i && lb;
      bit rq = rv && ra == i && !rb, rr = rv && ra == i && rb;
      if (m_own[i] == 0) begin
        if (lq) begin m_own[i] = 1; m_rp[i] = rq; end
        else if (rq) m_own[i] = 2;
      end else if (m_own[i] == 1) begin
        bit wait_r = (m_rp[i] && !rr) || rq;
        if (lr) begin m_own[i] = wait_r ? 2 : 0; m_rp[i] = 0; end
        else m_rp[i] = wait_r;
      end else begin
        bit wait_l = (m_lp[i] && !lr) || lq;
        if (rr) begin m_own[i] = wait_l ? 1 : 0; m_lp[i] = 0; end
        else m_lp[i] = wait_l;
      end
    end
  endtask

  task automatic cyc(input logic len, input logic lsem, input logic lwe, input int la, input logic [DW-1:0] ld,
                     input logic ren, input logic rsem, input logic rwe, input int ra, input logic [DW-1:0] rd);
    @(negedge clk);
    lt_en_n = len; lt_sem_n = lsem; lt_we_n = lwe; lt_addr = 3'(la); lt_wdata = ld;
    rt_en_n = ren; rt_sem_n = rsem; rt_we_n = rwe; rt_addr = 3'(ra); rt_wdata = rd;
    model(len && !lsem && !lwe, ld[0], la, ren && !rsem && !rwe, rd[0], ra);
  endtask

  task automatic lw(input int a, input logic [DW-1:0] d);
    cyc(1, 0, 0, a, d, 0, 1, 1, 0, '0);
  endtask
  task automatic rw(input int a, input logic [DW-1:0] d);
    cyc(0, 1, 1, 0, '0, 1, 0, 0, a, d);
  endtask

  // Read flag a from both sides and compare with expected status bits.
  task automatic peek(input string tag, input int a, input bit el, input bit er);
    cyc(1, 0, 1, a, '0, 1, 0, 1, a, '0);
    #2;
    chk({tag, " left"}, lt_rdata, {DW{el}});
    chk({tag, " right"}, rt_rdata, {DW{er}});
  endtask

  task automatic peek_model(input string tag, input int a);
    peek(tag, a, m_own[a] != 1, m_own[a] != 2);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_own[i] = 0; m_lp[i] = 0; m_rp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < 8; a++) peek("R11 reset free", a, 1, 1);

    lw(3, '0);            peek("R5 left takes free", 3, 0, 1);
    rw(3, '0);            peek("R6 right loses, no change", 3, 0, 1);
    lw(3, 36'h1);         peek("R7 handoff to right", 3, 1, 0);
    lw(3, '0);            peek("R6 left loses, no change", 3, 1, 0);
    rw(3, 36'h1);         peek("R7 handoff to left", 3, 0, 1);
    lw(3, 36'h1);         peek("R8 release to free", 3, 1, 1);

    rw(5, '0); lw(5, '0); peek("R6 left pending on 5", 5, 1, 0);
    lw(5, 36'h1);         peek("R9 cancel keeps holder", 5, 1, 0);
    rw(5, 36'h1);         peek("R9 freed after cancel", 5, 1, 1);

    cyc(1, 0, 0, 6, '0, 1, 0, 0, 6, '0); peek("R10 tie left wins", 6, 0, 1);
    lw(6, 36'h1);         peek("R10 right pending granted", 6, 1, 0);
    rw(6, 36'h1);         peek("R8 flag 6 free", 6, 1, 1);

    lw(2, 36'hF_FFFF_FFFF); peek("R3 bit0=1 is release only", 2, 1, 1);
    lw(2, 36'hF_FFFF_FFFE); peek("R3 upper bits ignored", 2, 0, 1);

    cyc(0, 0, 0, 1, '0, 0, 1, 1, 0, '0); peek("R1 enable low blocks", 1, 1, 1);
    cyc(1, 1, 0, 1, '0, 0, 1, 1, 0, '0); peek("R1 select high blocks", 1, 1, 1);
    cyc(0, 0, 1, 2, '0, 1, 1, 1, 2, '0); #2;
    chk("R1 idle read left ones", lt_rdata, '1);
    chk("R1 idle read right ones", rt_rdata, '1);

    for (int a = 0; a < 8; a++) peek_model("R2 flags independent", a);

    for (int s = 0; s < 1500; s++) begin
      logic [31:0] x = rnd(), y = rnd();
      cyc(x[0] | x[1], x[2] & x[3], x[4], int'(x[7:5]), {y[3:0], y, x[8]},
          x[9] | x[10], x[11] & x[12], x[13], int'(x[16:14]), {y[7:4], ~y, x[17]});
      for (int a = 0; a < 8; a++) peek_model("R2 R4 R5 R6 R7 R8 R9 R10 random", a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule